// File: doc/BRIEF.md
# Fifty-Percent-Duty Selectable Clock Divider

This block takes one fast clock and produces two slower clocks, one per output bank. A shared 3-bit code chooses the ratio: 2, 4 or 5. Every ratio gives a 50% duty cycle, the odd one included. For divide-by-5 the output stays high for two and a half input cycles. To get that half cycle, a phase made on the rising edge is ORed with a copy of itself taken on the falling edge.

Each bank has its own enable. A disabled bank drives its clock low. The shared counter keeps running, so a bank that is enabled again comes back in step with the other bank. The new ratio and the new enable value are both taken at the counter's terminal count, which is the same edge on which a new output period begins. A code or enable change therefore never produces a shortened pulse. The master reset is active low and takes effect at once. Its release is synchronised to the fast clock, and while it is asserted both outputs are low.

Top module: `duty_div`

## Requirements
- R1: While `rst_n` is low, `clk_a` and `clk_b` are both low. Asserting `rst_n` forces them low without waiting for a clock edge. After release, both outputs start toggling.
- R2: Code `3'b001` gives a period of 2 input cycles, high for 1 cycle.
- R3: Code `3'b011` gives a period of 4 input cycles, high for 2 cycles.
- R4: Code `3'b100` gives a period of 5 input cycles, high for exactly 2.5 cycles: it rises on a rising edge of the input and falls on a falling edge.
- R5: Codes `000`, `010`, `101`, `110` and `111` behave as divide-by-2.
- R6: A code change applies only at the end of the current output period. Every rise-to-rise interval therefore matches either the old ratio or the new ratio in full, and after the change the output settles on the new ratio.
- R7: Both banks divide by the same ratio, and their rising edges fall on the same input edge.
- R8: A bank whose enable is low drives its clock low at every sample, starting no later than the end of the period in progress. The other bank keeps running.
- R9: A bank that is enabled again starts on a period boundary. Its rising edges then coincide with those of the bank that stayed enabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_fast | input | 1 | Fast source clock |
| rst_n | input | 1 | Master reset, active low, asynchronous assert |
| div_code | input | 3 | Shared ratio code: 001 gives /2, 011 gives /4, 100 gives /5, any other value gives /2 |
| en_a | input | 1 | Bank A enable, active high |
| en_b | input | 1 | Bank B enable, active high |
| clk_a | output | 1 | Divided clock, bank A |
| clk_b | output | 1 | Divided clock, bank B |

## Verification
The bench samples both outputs at every half cycle and records the length of each period and its high time in half cycles. It sweeps all eight codes. With that resolution, a divide-by-5 built on one edge only shows up as a high time of 4 or 6 half cycles instead of 5. The bench switches codes at every offset within a period, so a design that loads the ratio mid-period shows a rise-to-rise interval that matches neither ratio. For enable changes, the bench looks for leaked high samples on a disabled bank and compares the rise times of the two banks after re-enable. A design that stopped the counter, or restarted it on enable, would fail the rise-time comparison.

// File: rtl/duty_div_pkg.sv
`timescale 1ns/1ps
package duty_div_pkg;
  localparam int CODE_W    = 3;
  localparam int CNT_W     = 3;
  localparam int NUM_BANKS = 2;
  localparam int RATIO_LO  = 2;
  localparam int RATIO_MID = 4;
  localparam int RATIO_HI  = 5;

  typedef logic [CNT_W-1:0]  cnt_t;
  typedef logic [CODE_W-1:0] code_t;

  // Sparse code decode; every unlisted code selects the smallest ratio.
  function automatic cnt_t ratio_of(code_t c);
    case (c)
      3'b001:  ratio_of = cnt_t'(RATIO_LO);
      3'b011:  ratio_of = cnt_t'(RATIO_MID);
      3'b100:  ratio_of = cnt_t'(RATIO_HI);
      default: ratio_of = cnt_t'(RATIO_LO);
    endcase
  endfunction
endpackage

// File: rtl/duty_div_rsync.sv
`timescale 1ns/1ps
module duty_div_rsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb sh_d = {sh_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rst_s = sh_q[STAGES-1];
endmodule

// File: rtl/duty_div_count.sv
`timescale 1ns/1ps
module duty_div_count
  import duty_div_pkg::*;
(
  input  logic  clk,
  input  logic  rst_s,
  input  code_t code,
  output logic  tc,
  output logic  ph_next,
  output logic  odd_next
);
  cnt_t cnt_q, cnt_d;
  cnt_t ratio_q, ratio_d;

  // Next-state: ratio is reloaded only at terminal count.
  always_comb begin
    tc       = (cnt_q == cnt_t'(ratio_q - cnt_t'(1)));
    ratio_d  = tc ? ratio_of(code) : ratio_q;
    cnt_d    = tc ? '0 : cnt_t'(cnt_q + cnt_t'(1));
    ph_next  = (cnt_d < (ratio_d >> 1));
    odd_next = ratio_d[0];
  end

  // Reset state places the counter at terminal count of a /2 period,
  // so the first edge after release starts a fresh period.
  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      cnt_q   <= cnt_t'(RATIO_LO - 1);
      ratio_q <= cnt_t'(RATIO_LO);
    end else begin
      cnt_q   <= cnt_d;
      ratio_q <= ratio_d;
    end
  end

  a_r6_ratio_at_tc: assert property (@(posedge clk) disable iff (!rst_s)
    (ratio_q != $past(ratio_q)) |-> $past(tc));

  a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!rst_s)
    cnt_q < ratio_q);
endmodule

// File: rtl/duty_div_bank.sv
`timescale 1ns/1ps
module duty_div_bank (
  input  logic clk,
  input  logic rst_s,
  input  logic en,
  input  logic tc,
  input  logic ph_next,
  input  logic odd_next,
  output logic dclk
);
  logic en_q, en_d;
  logic ph_q, ph_d;
  logic odd_q, odd_d;
  logic neg_q;

  always_comb begin
    en_d  = tc ? en : en_q;
    odd_d = tc ? odd_next : odd_q;
    ph_d  = en_d & ph_next;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      en_q  <= 1'b1;
      ph_q  <= 1'b0;
      odd_q <= 1'b0;
    end else begin
      en_q  <= en_d;
      ph_q  <= ph_d;
      odd_q <= odd_d;
    end
  end

  // Half-cycle retimed copy of the phase, used to stretch odd ratios.
  always_ff @(negedge clk or negedge rst_s) begin
    if (!rst_s) neg_q <= 1'b0;
    else        neg_q <= ph_q;
  end

  assign dclk = ph_q | (odd_q & neg_q);

  a_r8_rise_at_tc: assert property (@(posedge clk) disable iff (!rst_s)
    $rose(ph_q) |-> $past(tc));

  a_r9_en_at_tc: assert property (@(posedge clk) disable iff (!rst_s)
    (en_q != $past(en_q)) |-> $past(tc));

  a_r4_odd_at_tc: assert property (@(posedge clk) disable iff (!rst_s)
    (odd_q != $past(odd_q)) |-> $past(tc));
endmodule

// File: rtl/duty_div.sv
`timescale 1ns/1ps
module duty_div
  import duty_div_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_fast,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] div_code,
  input  logic              en_a,
  input  logic              en_b,
  output logic              clk_a,
  output logic              clk_b
);
  logic                 rst_s;
  logic                 tc, ph_next, odd_next;
  logic [NUM_BANKS-1:0] en_vec;
  logic [NUM_BANKS-1:0] out_vec;

  duty_div_rsync #(.STAGES(SYNC_STAGES)) u_rsync (
    .clk(clk_fast), .rst_n(rst_n), .rst_s(rst_s)
  );

  duty_div_count u_count (
    .clk(clk_fast), .rst_s(rst_s), .code(div_code),
    .tc(tc), .ph_next(ph_next), .odd_next(odd_next)
  );

  assign en_vec = {en_b, en_a};

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    duty_div_bank u_bank (
      .clk(clk_fast), .rst_s(rst_s), .en(en_vec[g]), .tc(tc),
      .ph_next(ph_next), .odd_next(odd_next), .dclk(out_vec[g])
    );
  end

  assign clk_a = out_vec[0];
  assign clk_b = out_vec[1];

  a_r1_low_in_reset: assert property (@(posedge clk_fast)
    !rst_s |-> (!clk_a && !clk_b));
endmodule

// File: tb/sim_duty_div.sv
`timescale 1ns/1ps
module sim_duty_div;
  logic       clk_fast = 1'b0;
  logic       rst_n;
  logic [2:0] div_code;
  logic       en_a, en_b;
  logic       clk_a, clk_b;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  duty_div u0 (
    .clk_fast(clk_fast), .rst_n(rst_n), .div_code(div_code),
    .en_a(en_a), .en_b(en_b), .clk_a(clk_a), .clk_b(clk_b)
  );

  always #2 clk_fast = ~clk_fast;

  // Half-cycle monitor: period and high time in half cycles per bank.
  int     n [2];
  int     per [2][64];
  int     hi [2][64];
  longint rt [2][64];
  int     run [2];
  int     hr [2];
  int     highs [2];
  bit     prv [2];
  bit     seen [2];
  logic   cur;

  always @(clk_fast) begin
    #1;
    for (int b = 0; b < 2; b++) begin
      cur = (b == 0) ? clk_a : clk_b;
      if (cur) highs[b]++;
      if (cur && !prv[b]) begin
        if (seen[b] && n[b] < 64) begin
          per[b][n[b]] = run[b];
          hi[b][n[b]]  = hr[b];
          rt[b][n[b]]  = $time;
          n[b]++;
        end
        seen[b] = 1; run[b] = 1; hr[b] = 1;
      end else begin
        run[b]++;
        if (cur) hr[b]++;
      end
      prv[b] = cur;
    end
  end

  task automatic clr();
    for (int b = 0; b < 2; b++) begin
      n[b] = 0; seen[b] = 0; highs[b] = 0;
    end
  endtask

  task automatic step(int k);
    repeat (k) @(negedge clk_fast);
  endtask

  task automatic chk(string tag, longint act, longint exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int ratio_exp(logic [2:0] c);
    if (c == 3'b001) return 2;
    if (c == 3'b011) return 4;
    if (c == 3'b100) return 5;
    return 2;
  endfunction

  function automatic string tag_of(logic [2:0] c);
    if (c == 3'b001) return "R2 /2";
    if (c == 3'b011) return "R3 /4";
    if (c == 3'b100) return "R4 /5";
    return "R5 unused code";
  endfunction

  initial begin
    int r, ro, rn, errs;
    logic [2:0] pairs [4][2];
    pairs[0] = '{3'b100, 3'b001};
    pairs[1] = '{3'b001, 3'b100};
    pairs[2] = '{3'b011, 3'b100};
    pairs[3] = '{3'b100, 3'b011};

    rst_n = 1'b0; en_a = 1'b1; en_b = 1'b1; div_code = 3'b001;
    clr();
    step(6);
    chk("R1 low in reset", highs[0] + highs[1], 0);
    rst_n = 1'b1;
    step(10);
    clr();
    step(12);
    chk("R1 running after release", (n[0] >= 3) && (n[1] >= 3), 1);

    // Sweep every code on both banks.
    for (int c = 0; c < 8; c++) begin
      div_code = 3'(c);
      r = ratio_exp(3'(c));
      step(15);
      clr();
      step(40);
      for (int b = 0; b < 2; b++) begin
        chk({tag_of(3'(c)), " enough periods"}, n[b] >= 3, 1);
        for (int k = 0; k < n[b]; k++) begin
          chk({tag_of(3'(c)), " period"}, per[b][k], 2 * r);
          chk({tag_of(3'(c)), " high"}, hi[b][k], r);
        end
      end
      chk("R7 same count", n[0], n[1]);
      chk("R7 aligned rise", rt[0][0] - rt[1][0], 0);
    end

    // Code changes at every offset inside a period.
    for (int p = 0; p < 4; p++) begin
      for (int off = 0; off < 6; off++) begin
        div_code = pairs[p][0];
        ro = ratio_exp(pairs[p][0]);
        rn = ratio_exp(pairs[p][1]);
        step(15 + off);
        div_code = pairs[p][1];
        clr();
        step(40);
        errs = 0;
        for (int k = 0; k < n[0]; k++)
          if (!((per[0][k] == 2*ro && hi[0][k] == ro) ||
                (per[0][k] == 2*rn && hi[0][k] == rn))) errs++;
        chk("R6 whole periods only", errs, 0);
        chk("R6 settles to new ratio", per[0][n[0]-1], 2 * rn);
      end
    end

    // Disable bank A mid-period, bank B keeps going.
    div_code = 3'b100;
    step(13);
    en_a = 1'b0;
    step(12);
    clr();
    step(40);
    chk("R8 disabled bank low", highs[0], 0);
    chk("R8 other bank runs", n[1] >= 5, 1);
    chk("R8 other bank period", per[1][0], 10);

    // Re-enable at an odd offset; phase must match bank B.
    step(3);
    en_a = 1'b1;
    step(12);
    clr();
    step(40);
    chk("R9 re-enabled count", n[0], n[1]);
    chk("R9 re-enabled aligned", rt[0][0] - rt[1][0], 0);
    chk("R9 re-enabled period", per[0][0], 10);
    chk("R9 re-enabled high", hi[0][0], 5);

    // Reset in the middle of operation acts at once.
    #1;
    rst_n = 1'b0;
    #0.5;
    chk("R1 immediate low A", clk_a, 0);
    chk("R1 immediate low B", clk_b, 0);
    clr();
    step(8);
    chk("R1 held low", highs[0] + highs[1], 0);
    rst_n = 1'b1;
    step(10);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL R1 watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule